// File: doc/BRIEF.md
# Codec Power-Down and Loopback Controller

This block is the digital control section of an audio codec. It owns the bank of control registers, takes the part into and out of power-down, makes sure an offset calibration runs once the internal reference has had time to settle, and chooses which self-test loopback route, if any, is active. The converters, the voltage reference and the companding logic sit outside this block. It drives them only through control signals.

A high level on the power-down input shuts off the reference (and the common-mode supply, which shares the same enable). It also returns every control register to its reset value, cancels any calibration in flight and turns the time-slot output into a direct copy of the time-slot input. Once the power-down input is low again, the host asks for a calibration in one of two ways: by writing a control register, or by pulsing the codec reset input low and then high. The block holds that request and only issues the calibration start once a fixed settling count has elapsed since power-down ended. In the loopback register, one bit enables loopback and a second bit picks the digital-only route or the route through the converters.

Top module: `codec_pwr_ctl`

## Requirements
- R1: `ref_en` is low in the cycle after a clock edge at which `pwrdn_i` is high, and high in the cycle after an edge at which `pwrdn_i` is low. System reset forces it low.
- R2: At any clock edge where `pwrdn_i` is high or `chip_rst_n` is low, every control register loads its reset value from `RST_WORD`, and register writes are ignored. Register k occupies bits [8k+7:8k] of `ctrl_word`.
- R3: While `pwrdn_i` is high, `ts_out` equals `ts_in` with no clock in the path. Otherwise `ts_out` is `ts_in` delayed by one clock.
- R4: A rising edge of `chip_rst_n` (low at one edge, high at the next), seen while `pwrdn_i` is low, requests a calibration.
- R5: A write (`wr_en` high, `pwrdn_i` low, `chip_rst_n` high) loads `wr_data` into register `wr_addr` at that edge and also requests a calibration.
- R6: `cal_start` is a one-cycle pulse. It is only issued once `SETTLE_CYC` consecutive edges with `pwrdn_i` low have passed since power-down or reset. A request made earlier is held, and the pulse comes in the first cycle this allows.
- R7: If bit 1 of register 3 is set and bit 0 is clear, `dd_sel` is high and `dad_sel` is low.
- R8: If bits 1 and 0 of register 3 are both set, `dad_sel` is high. If bit 1 is clear, both selects are low, whatever bit 0 holds.
- R9: `cal_busy` is high for exactly `CAL_CYC` cycles, starting in the cycle of `cal_start`. A request that arrives while busy is held, and it starts the next calibration only after `cal_busy` falls.
- R10: A clock edge with `pwrdn_i` high clears `cal_busy`, `cal_start` and any held request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| pwrdn_i | input | 1 | Power-down request, high = powered down |
| chip_rst_n | input | 1 | Codec reset pin, active low |
| wr_en | input | 1 | Control-register write strobe |
| wr_addr | input | ADDR_W | Register index for the write |
| wr_data | input | DATA_W | Write data |
| ts_in | input | 1 | Time-slot chain input |
| ts_out | output | 1 | Time-slot chain output |
| ref_en | output | 1 | Reference and common-mode supply enable |
| cal_start | output | 1 | One-cycle offset-calibration start |
| cal_busy | output | 1 | Calibration in progress |
| dd_sel | output | 1 | Digital-to-digital loopback select |
| dad_sel | output | 1 | Digital-analog-digital loopback select |
| ctrl_word | output | NREG*DATA_W | Current control-register contents |

## Verification
Some properties are checked on every cycle inside the RTL. The two loopback selects are never high together. Power-down clears both selects, the reference enable and any calibration activity on the very next cycle. A calibration start only follows a cycle in which the settling count was complete, every start is a single-cycle pulse, and `cal_busy` is high whenever a start is. Other behaviour only shows up in the bench's scenarios, because it depends on history. These are: a request made during settling that is held and then fires at exactly the right cycle, a request queued behind a running calibration, a reset pulse on the codec reset pin, register writes ignored during power-down, and the delayed versus transparent time-slot path.

// File: rtl/codec_pc_pkg.sv
package codec_pc_pkg;

  typedef enum logic [1:0] {
    LB_OFF = 2'd0,
    LB_DD  = 2'd1,
    LB_DAD = 2'd2
  } lb_path_e;

endpackage

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
  import codec_pc_pkg::*;
#(
  parameter int NREG       = 4,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int LB_ADDR    = 3,
  parameter int LB_EN_BIT  = 1,
  parameter int LB_DAD_BIT = 0,
  parameter logic [NREG*DATA_W-1:0] RST_WORD = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_i,
  input  logic                   wr_ok_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic [NREG*DATA_W-1:0] word_o,
  output lb_path_e               path_o
);

  logic [DATA_W-1:0] regs_q [NREG];

  // one register per slot; clear has priority over a write
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        regs_q[g] <= RST_WORD[g*DATA_W +: DATA_W];
      end else if (wr_ok_i && (int'(wr_addr_i) == g)) begin
        regs_q[g] <= wr_data_i;
      end
    end
    assign word_o[g*DATA_W +: DATA_W] = regs_q[g];
  end

  logic lb_en, lb_dad;
  assign lb_en  = regs_q[LB_ADDR][LB_EN_BIT];
  assign lb_dad = regs_q[LB_ADDR][LB_DAD_BIT];

  always_comb begin
    if (!lb_en)     path_o = LB_OFF;
    else if (lb_dad) path_o = LB_DAD;
    else            path_o = LB_DD;
  end

  // R2
  clear_restores_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (word_o == RST_WORD));

endmodule

// File: rtl/codec_settle_timer.sv
module codec_settle_timer #(
  parameter int SETTLE_CYC = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pwrdn_i,
  output logic settled_o
);

  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || pwrdn_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign settled_o = (cnt_q == LIMIT);

  // R6
  settle_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (settled_o && !pwrdn_i) |=> settled_o);

  // R6
  settle_reset_chk: assert property (@(posedge clk) disable iff (rst)
    pwrdn_i |=> !settled_o);

endmodule

// File: rtl/codec_cal_seq.sv
module codec_cal_seq #(
  parameter int CAL_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic pwrdn_i,
  input  logic settled_i,
  input  logic req_i,
  output logic cal_start_o,
  output logic cal_busy_o
);

  localparam int BW = $clog2(CAL_CYC + 1);
  localparam logic [BW-1:0] LOAD = BW'(CAL_CYC);

  logic [BW-1:0] busy_q;
  logic          pend_q;
  logic          fire;

  assign fire = pend_q && settled_i && (busy_q == '0) && !pwrdn_i;

  always_ff @(posedge clk) begin
    if (rst || pwrdn_i) begin
      busy_q      <= '0;
      pend_q      <= 1'b0;
      cal_start_o <= 1'b0;
    end else begin
      cal_start_o <= fire;
      pend_q      <= (pend_q && !fire) || req_i;
      if (fire)              busy_q <= LOAD;
      else if (busy_q != '0) busy_q <= busy_q - 1'b1;
    end
  end

  assign cal_busy_o = (busy_q != '0);

  // R6
  start_after_settle_chk: assert property (@(posedge clk) disable iff (rst)
    cal_start_o |-> $past(settled_i));

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    cal_start_o |=> !cal_start_o);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cal_start_o |-> cal_busy_o);

  // R10
  pd_abort_chk: assert property (@(posedge clk) disable iff (rst)
    pwrdn_i |=> (!cal_busy_o && !cal_start_o));

endmodule

// File: rtl/codec_pwr_ctl.sv
module codec_pwr_ctl
  import codec_pc_pkg::*;
#(
  parameter int NREG       = 4,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int LB_ADDR    = 3,
  parameter int LB_EN_BIT  = 1,
  parameter int LB_DAD_BIT = 0,
  parameter int SETTLE_CYC = 5_000_000,
  parameter int CAL_CYC    = 64,
  parameter logic [NREG*DATA_W-1:0] RST_WORD = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pwrdn_i,
  input  logic                   chip_rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   ts_in,
  output logic                   ts_out,
  output logic                   ref_en,
  output logic                   cal_start,
  output logic                   cal_busy,
  output logic                   dd_sel,
  output logic                   dad_sel,
  output logic [NREG*DATA_W-1:0] ctrl_word
);

  logic     crn_q, ts_q;
  logic     wr_ok, rst_rise, cal_req, reg_clr, settled;
  lb_path_e path;

  always_ff @(posedge clk) begin
    if (rst) begin
      crn_q  <= 1'b1;
      ts_q   <= 1'b0;
      ref_en <= 1'b0;
    end else begin
      crn_q  <= chip_rst_n;
      ts_q   <= ts_in;
      ref_en <= !pwrdn_i;
    end
  end

  assign wr_ok    = wr_en && !pwrdn_i && chip_rst_n;
  assign rst_rise = chip_rst_n && !crn_q && !pwrdn_i;
  assign cal_req  = wr_ok || rst_rise;
  assign reg_clr  = pwrdn_i || !chip_rst_n;

  // transparent chain while powered down
  assign ts_out = pwrdn_i ? ts_in : ts_q;

  codec_ctl_regs #(
    .NREG(NREG), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LB_ADDR(LB_ADDR),
    .LB_EN_BIT(LB_EN_BIT), .LB_DAD_BIT(LB_DAD_BIT), .RST_WORD(RST_WORD)
  ) u_regs (
    .clk(clk), .rst(rst), .clr_i(reg_clr), .wr_ok_i(wr_ok),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .word_o(ctrl_word), .path_o(path)
  );

  codec_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .pwrdn_i(pwrdn_i), .settled_o(settled)
  );

  codec_cal_seq #(.CAL_CYC(CAL_CYC)) u_cal (
    .clk(clk), .rst(rst), .pwrdn_i(pwrdn_i), .settled_i(settled),
    .req_i(cal_req), .cal_start_o(cal_start), .cal_busy_o(cal_busy)
  );

  assign dd_sel  = (path == LB_DD);
  assign dad_sel = (path == LB_DAD);

  // R1
  ref_off_chk: assert property (@(posedge clk) disable iff (rst)
    pwrdn_i |=> !ref_en);

  // R8
  path_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(dd_sel && dad_sel));

  // R2
  pd_loop_off_chk: assert property (@(posedge clk) disable iff (rst)
    pwrdn_i |=> (!dd_sel && !dad_sel));

endmodule

// File: tb/codec_pwr_ctl_bench.sv
module codec_pwr_ctl_bench;

  localparam int NREG = 4;
  localparam int DW   = 8;
  localparam int AW   = 2;
  localparam int S    = 20;
  localparam int CAL  = 6;
  localparam logic [NREG*DW-1:0] RW = 32'h0011_22A5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd = 1'b0, crn = 1'b1, we = 1'b0, ts = 1'b0;
  logic [AW-1:0] wa = '0;
  logic [DW-1:0] wd = '0;
  logic ts_out, ref_en, cal_start, cal_busy, dd_sel, dad_sel;
  logic [NREG*DW-1:0] ctrl_word;

  always #4 clk = ~clk;

  codec_pwr_ctl #(
    .NREG(NREG), .DATA_W(DW), .ADDR_W(AW), .SETTLE_CYC(S), .CAL_CYC(CAL),
    .RST_WORD(RW)
  ) u_codec_pwr_ctl (
    .clk(clk), .rst(rst), .pwrdn_i(pd), .chip_rst_n(crn), .wr_en(we),
    .wr_addr(wa), .wr_data(wd), .ts_in(ts), .ts_out(ts_out), .ref_en(ref_en),
    .cal_start(cal_start), .cal_busy(cal_busy), .dd_sel(dd_sel),
    .dad_sel(dad_sel), .ctrl_word(ctrl_word)
  );

  // behavioural reference model
  int   m_cnt, m_busy;
  bit   m_pend, m_start, m_ref, m_tsq, m_crnq;
  logic [DW-1:0] m_reg [NREG];
  int   errors = 0, checks = 0;
  bit   done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_busy = 0; m_pend = 0; m_start = 0;
      m_ref = 0; m_tsq = 0; m_crnq = 1;
      for (int k = 0; k < NREG; k++) m_reg[k] = RW[k*DW +: DW];
    end else begin
      bit fire, req;
      fire = m_pend && (m_cnt == S) && (m_busy == 0) && !pd;
      req  = !pd && ((we && crn) || (crn && !m_crnq));
      if (pd) begin
        m_pend = 0; m_busy = 0; m_start = 0;
      end else begin
        m_start = fire;
        if (fire) m_busy = CAL;
        else if (m_busy > 0) m_busy = m_busy - 1;
        m_pend = (m_pend && !fire) || req;
      end
      if (pd) m_cnt = 0;
      else if (m_cnt < S) m_cnt = m_cnt + 1;
      if (pd || !crn) begin
        for (int k = 0; k < NREG; k++) m_reg[k] = RW[k*DW +: DW];
      end else if (we) begin
        m_reg[wa] = wd;
      end
      m_ref = !pd; m_tsq = ts; m_crnq = crn;
    end
  end

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [NREG*DW-1:0] ew;
    logic lb_en, lb_dad;
    for (int k = 0; k < NREG; k++) ew[k*DW +: DW] = m_reg[k];
    lb_en  = m_reg[3][1];
    lb_dad = m_reg[3][0];
    chk1("R1 ref_en", ref_en, m_ref);
    chk1("R4 R6 cal_start", cal_start, m_start);
    chk1("R9 R10 cal_busy", cal_busy, m_busy != 0);
    chk1("R7 dd_sel", dd_sel, lb_en && !lb_dad);
    chk1("R8 dad_sel", dad_sel, lb_en && lb_dad);
    checks++;
    if (ctrl_word !== ew) begin
      errors++;
      $display("FAIL R2/R5 ctrl_word: actual=%h expected=%h at %0t", ctrl_word, ew, $time);
    end
  endtask

  // compare current outputs, then drive the next cycle's inputs
  task automatic step(input logic p, input logic c, input logic w,
                      input int a, input int d);
    @(negedge clk);
    compare();
    pd = p; crn = c; we = w; wa = AW'(a); wd = DW'(d); ts = 1'($urandom);
    #1;
    chk1("R3 ts_out", ts_out, pd ? ts : m_tsq);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(1);                                  // reset state checked here
    step(1'b0, 1'b1, 1'b1, 0, 8'h5A);         // early write: held (R6)
    idle(S + 3);                              // fires once settled
    step(1'b0, 1'b1, 1'b1, 3, 8'h02);         // DD path, queued during busy (R9)
    idle(CAL + 6);
    step(1'b0, 1'b1, 1'b1, 3, 8'h03);         // DAD path
    idle(CAL + 3);
    step(1'b0, 1'b1, 1'b1, 3, 8'h01);         // enable clear
    idle(CAL + 3);
    step(1'b0, 1'b1, 1'b1, 3, 8'h02);
    idle(2);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b1, 2, 8'hFF); // R2 held in reset
    step(1'b0, 1'b1, 1'b0, 0, 0);             // R4 rising edge
    idle(CAL + 4);
    step(1'b0, 1'b1, 1'b1, 1, 8'h77);
    idle(2);                                  // mid-busy
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, 3, 8'h03); // R10, writes ignored
    step(1'b0, 1'b1, 1'b1, 3, 8'h03);         // request during settle
    idle(S + CAL + 4);
    for (int i = 0; i < 4000; i++) begin
      logic p;
      p = ($urandom % 40) == 0 ? 1'b1 : pd && (($urandom % 4) != 0);
      step(p, ($urandom % 30) != 0, ($urandom % 12) == 0,
           int'($urandom % NREG), int'($urandom % 256));
    end
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule